// File: doc/BRIEF.md
# Register Bit-Field Operation Unit

This unit carries out bit-field instructions whose operand is a 32-bit data register. A field is defined by an offset and a width. The offset is counted from the most significant bit. Fields that run past bit 0 continue at bit 31. The unit supports eight operations on that field: test, unsigned extract, signed extract, change (invert), clear, set, find-first-one and insert.

The unit takes the 16-bit opcode word, the 16-bit extension word and a start strobe. It names the registers it needs on four select outputs: width, offset, field operand and insert source. The surrounding register file returns their contents on four data inputs in the same cycle. One cycle after start, the unit presents a done pulse, the registered results and the N/Z/V/C flags. It also presents write strobes for the field register and for the destination register. The surrounding pipeline uses these strobes to update the register file.

Top module: `bitfield_unit`

## Requirements
- R1: The width source is selected by extension bit 5. When bit 5 is 1, the width is the low 5 bits of the register named by extension bits 2:0. When bit 5 is 0, the width is extension bits 4:0. A 5-bit width code of 0 means 32 bits. Any other code n means n bits.
- R2: The offset source is selected by extension bit 11. When bit 11 is 1, the offset is the low 5 bits of the register named by extension bits 8:6, so it is taken modulo 32. When bit 11 is 0, the offset is extension bits 10:6. Offset 0 is bit 31. The field runs toward bit 0 and wraps from bit 0 to bit 31.
- R3: Opcode bits 11:8 choose the operation as follows: 8 test, 9 unsigned extract, B signed extract, A change, C clear, D find-first-one, E set, F insert. Codes 0 to 7 write no register.
- R4: Unsigned extract writes the field, zero-extended, to the register named by extension bits 14:12.
- R5: Signed extract writes the field to that same destination, sign-extended from the field's most significant bit.
- R6: Change, clear and set write the operand register (opcode bits 2:0) back with the field bits inverted, zeroed or set. All bits outside the field keep their values.
- R7: Insert takes its value from the register named by extension bits 14:12. It writes the low width bits of that value into the field of the operand register, with the value's most significant bit at the offset. All other bits stay unchanged.
- R8: Find-first-one writes a result to the destination register. The result is the offset plus the number of leading zeros in the field. If the field is all zero, the result is the offset plus the width.
- R9: Flags are presented as {N,Z,V,C} on bits 3:0. For all operations except insert, the flags come from the field value before any change, left-justified. For insert, they come from the inserted low width bits, left-justified. N is the top bit, Z is 1 when all field bits are zero, and V and C are 0.
- R10: The done signal pulses for one cycle, one cycle after start. The field-register write strobe and the destination write strobe are asserted only together with done. Test asserts neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches one operation with the words presented this cycle |
| op_word | input | 16 | Opcode word |
| ext_word | input | 16 | Extension word |
| wid_sel | output | 3 | Register index for a variable width |
| wid_data | input | 32 | Contents of the width register |
| ofs_sel | output | 3 | Register index for a variable offset |
| ofs_data | input | 32 | Contents of the offset register |
| src_sel | output | 3 | Register index of the field operand |
| src_data | input | 32 | Contents of the field operand register |
| ins_sel | output | 3 | Register index of the insert source |
| ins_data | input | 32 | Contents of the insert source register |
| done | output | 1 | One-cycle completion pulse |
| fld_we | output | 1 | Write strobe for the modified operand register |
| fld_idx | output | 3 | Index of the operand register to write |
| fld_val | output | 32 | New operand register value |
| dst_we | output | 1 | Write strobe for the destination register |
| dst_idx | output | 3 | Index of the destination register |
| dst_val | output | 32 | Extract or find-first-one result |
| flags | output | 4 | {N,Z,V,C} |

## Verification
All register reads and the computation happen in the cycle that start is high. Every result, flag and strobe is captured at the next rising edge, so everything is due exactly one cycle after start. The bench raises start on a falling edge and lowers it on the next falling edge. It compares done, the strobes, the indices, the values and the flags at that second falling edge. It then looks one more cycle ahead to confirm that done and both strobes have dropped.

// File: rtl/bitfield_unit.sv
module bitfield_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] op_word,
  input  logic [15:0] ext_word,
  output logic [2:0]  wid_sel,
  input  logic [31:0] wid_data,
  output logic [2:0]  ofs_sel,
  input  logic [31:0] ofs_data,
  output logic [2:0]  src_sel,
  input  logic [31:0] src_data,
  output logic [2:0]  ins_sel,
  input  logic [31:0] ins_data,
  output logic        done,
  output logic        fld_we,
  output logic [2:0]  fld_idx,
  output logic [31:0] fld_val,
  output logic        dst_we,
  output logic [2:0]  dst_idx,
  output logic [31:0] dst_val,
  output logic [3:0]  flags
);
  localparam logic [3:0] K_TST = 4'h8, K_EXU = 4'h9, K_CHG = 4'hA, K_EXS = 4'hB,
                         K_CLR = 4'hC, K_FFO = 4'hD, K_SET = 4'hE, K_INS = 4'hF;

  wire [3:0] kind = op_word[11:8];

  assign wid_sel = ext_word[2:0];
  assign ofs_sel = ext_word[8:6];
  assign src_sel = op_word[2:0];
  assign ins_sel = ext_word[14:12];

  wire [4:0] wm1   = (ext_word[5] ? wid_data[4:0] : ext_word[4:0]) - 5'd1;
  wire [5:0] width = {1'b0, wm1} + 6'd1;
  wire [4:0] sh    = ~wm1;
  wire [4:0] off   = ext_word[11] ? ofs_data[4:0] : ext_word[10:6];

  wire [63:0] rl_src  = {src_data, src_data} << off;
  wire [31:0] aligned = rl_src[63:32];
  wire [31:0] top_msk = ~(32'h7fff_ffff >> wm1);
  wire [63:0] rr_msk  = {top_msk, top_msk} >> off;
  wire [31:0] reg_msk = rr_msk[31:0];
  wire [31:0] fld_top = aligned & top_msk;
  wire [31:0] ins_top = ins_data << sh;
  wire [63:0] rr_ins  = {ins_top, ins_top} >> off;
  wire [31:0] ext_u   = aligned >> sh;
  wire [31:0] ext_s   = $signed(aligned) >>> sh;

  logic [5:0] lz;
  always_comb begin
    lz = width;
    for (int i = 0; i < 32; i++)
      if (fld_top[i]) lz = 6'(31 - i);
  end
  wire [31:0] ffo_val = {27'd0, off} + {26'd0, lz};

  logic [31:0] new_fld, new_dst;
  always_comb begin
    new_fld = src_data;
    new_dst = 32'd0;
    case (kind)
      K_CHG: new_fld = src_data ^ reg_msk;
      K_CLR: new_fld = src_data & ~reg_msk;
      K_SET: new_fld = src_data | reg_msk;
      K_INS: new_fld = (src_data & ~reg_msk) | rr_ins[31:0];
      K_EXU: new_dst = ext_u;
      K_EXS: new_dst = ext_s;
      K_FFO: new_dst = ffo_val;
      default: ;
    endcase
  end

  wire        mod_op  = (kind == K_CHG) || (kind == K_CLR) || (kind == K_SET) || (kind == K_INS);
  wire        res_op  = (kind == K_EXU) || (kind == K_EXS) || (kind == K_FFO);
  wire [31:0] flg_src = (kind == K_INS) ? ins_top : fld_top;
  wire        unused  = (kind == K_TST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      fld_we  <= 1'b0;
      dst_we  <= 1'b0;
      fld_idx <= 3'd0;
      dst_idx <= 3'd0;
      fld_val <= 32'd0;
      dst_val <= 32'd0;
      flags   <= 4'd0;
    end else begin
      done   <= start;
      fld_we <= start & mod_op & ~unused;
      dst_we <= start & res_op;
      if (start) begin
        fld_idx <= op_word[2:0];
        dst_idx <= ext_word[14:12];
        fld_val <= new_fld;
        dst_val <= new_dst;
        flags   <= {flg_src[31], flg_src == 32'd0, 2'b00};
      end
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic       fld_we,
  input logic       dst_we,
  input logic [3:0] flags
);
  // R10
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
  // R10
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start));
  // R10
  fld_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) fld_we |-> done);
  // R10
  dst_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) dst_we |-> done);
  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fld_we && dst_we));
  // R9
  vc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> flags[1:0] == 2'b00);
  // R9
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && flags[2]) |-> !flags[3]);
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .fld_we(fld_we), .dst_we(dst_we), .flags(flags)
);

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] op_word = 16'd0, ext_word = 16'd0;
  logic [2:0]  wid_sel, ofs_sel, src_sel, ins_sel, fld_idx, dst_idx;
  logic [31:0] fld_val, dst_val;
  logic        done, fld_we, dst_we;
  logic [3:0]  flags;
  logic [31:0] rf [8];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitfield_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word), .ext_word(ext_word),
    .wid_sel(wid_sel), .wid_data(rf[wid_sel]), .ofs_sel(ofs_sel), .ofs_data(rf[ofs_sel]),
    .src_sel(src_sel), .src_data(rf[src_sel]), .ins_sel(ins_sel), .ins_data(rf[ins_sel]),
    .done(done), .fld_we(fld_we), .fld_idx(fld_idx), .fld_val(fld_val),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_val(dst_val), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] op, input logic [15:0] ex,
                       output logic e_fw, output logic e_dw,
                       output logic [31:0] e_fv, output logic [31:0] e_dv, output logic [3:0] e_fl);
    logic [4:0]  wc;
    int          w, o, p, first;
    logic [31:0] src, ins, fu, msk, nins, left, ileft, fs;
    logic [3:0]  k;
    k   = op[11:8];
    wc  = ex[5] ? rf[ex[2:0]][4:0] : ex[4:0];
    w   = (wc == 5'd0) ? 32 : int'(wc);
    o   = ex[11] ? int'(rf[ex[8:6]][4:0]) : int'(ex[10:6]);
    src = rf[op[2:0]];
    ins = rf[ex[14:12]];
    fu = 0; msk = 0; nins = src; first = -1;
    for (int i = 0; i < w; i++) begin
      p = 31 - ((o + i) % 32);
      fu = {fu[30:0], src[p]};
      msk[p] = 1'b1;
      if (src[p] && first < 0) first = i;
      nins[p] = ins[w - 1 - i];
    end
    left  = fu << (32 - w);
    ileft = ins << (32 - w);
    fs = fu;
    if (w < 32 && fu[w-1]) fs = fu | (32'hffff_ffff << w);
    e_fw = 0; e_dw = 0; e_fv = 32'd0; e_dv = 32'd0;
    case (k)
      4'hA: begin e_fw = 1; e_fv = src ^ msk; end
      4'hC: begin e_fw = 1; e_fv = src & ~msk; end
      4'hE: begin e_fw = 1; e_fv = src | msk; end
      4'hF: begin e_fw = 1; e_fv = nins; end
      4'h9: begin e_dw = 1; e_dv = fu; end
      4'hB: begin e_dw = 1; e_dv = fs; end
      4'hD: begin e_dw = 1; e_dv = 32'(o + ((first < 0) ? w : first)); end
      default: ;
    endcase
    if (k == 4'hF) e_fl = {ileft[31], ileft == 32'd0, 2'b00};
    else           e_fl = {left[31], left == 32'd0, 2'b00};
  endtask

  task automatic run(input logic [15:0] op, input logic [15:0] ex, input string req);
    logic e_fw, e_dw;
    logic [31:0] e_fv, e_dv;
    logic [3:0] e_fl;
    model(op, ex, e_fw, e_dw, e_fv, e_dv, e_fl);
    op_word = op; ext_word = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R10 done"}, 32'(done), 32'd1);
    chk({req, " R3 fld_we"}, 32'(fld_we), 32'(e_fw));
    chk({req, " R3 dst_we"}, 32'(dst_we), 32'(e_dw));
    chk({req, " R9 flags"}, 32'(flags), 32'(e_fl));
    if (e_fw) begin
      chk({req, " R6 fld_idx"}, 32'(fld_idx), 32'(op[2:0]));
      chk({req, " R6/R7 fld_val"}, fld_val, e_fv);
    end
    if (e_dw) begin
      chk({req, " R4 dst_idx"}, 32'(dst_idx), 32'(ex[14:12]));
      chk({req, " R4/R5/R8 dst_val"}, dst_val, e_dv);
    end
    @(negedge clk);
    chk({req, " R10 done pulse ends"}, 32'({done, fld_we, dst_we}), 32'd0);
  endtask

  function automatic logic [15:0] mk_op(input logic [3:0] k, input logic [2:0] r);
    return {4'hE, k, 2'b11, 3'b000, r};
  endfunction

  function automatic logic [15:0] mk_ext(input logic vo, input logic [4:0] o, input logic vw,
                                         input logic [4:0] w, input logic [2:0] d);
    return {1'b0, d, vo, o, vw, w};
  endfunction

  initial begin
    logic [3:0] kinds [8];
    kinds = '{4'h8, 4'h9, 4'hB, 4'hA, 4'hC, 4'hD, 4'hE, 4'hF};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset state", 32'({done, fld_we, dst_we, flags}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) rf[i] = 32'h0;
    rf[1] = 32'hF000_000F;
    // R1: width code 0 means 32, unsigned extract of the whole register
    run(mk_op(4'h9, 3'd1), mk_ext(0, 5'd0, 0, 5'd0, 3'd2), "R1 width32");
    // R2: wrap from bit 0 to bit 31, offset 28 width 8 gives 0xFF
    run(mk_op(4'h9, 3'd1), mk_ext(0, 5'd28, 0, 5'd8, 3'd2), "R2 wrap");
    // R5: signed extract of negative field
    run(mk_op(4'hB, 3'd1), mk_ext(0, 5'd0, 0, 5'd6, 3'd3), "R5 signed");
    // R8: all-zero field returns offset plus width
    run(mk_op(4'hD, 3'd1), mk_ext(0, 5'd8, 0, 5'd10, 3'd4), "R8 ffo zero");
    // R8: find first one in wrapped field
    run(mk_op(4'hD, 3'd1), mk_ext(0, 5'd20, 0, 5'd16, 3'd4), "R8 ffo");
    // R2: variable offset taken modulo 32, R1 variable width
    rf[5] = 32'h0000_0FE3; rf[6] = 32'h0000_0044;
    run(mk_op(4'hC, 3'd1), mk_ext(1, 5'd5, 1, 5'd6, 3'd0), "R2 var ofs");
    // R7: insert with wrap
    rf[7] = 32'h0000_00A5;
    run(mk_op(4'hF, 3'd1), mk_ext(0, 5'd30, 0, 5'd8, 3'd7), "R7 insert");
    // R3: test and codes 0-7 write nothing
    run(mk_op(4'h8, 3'd1), mk_ext(0, 5'd3, 0, 5'd5, 3'd2), "R3 test");
    run(mk_op(4'h2, 3'd1), mk_ext(0, 5'd3, 0, 5'd5, 3'd2), "R3 undefined");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] k;
      for (int i = 0; i < 8; i++) rf[i] = $urandom;
      k = (n % 10 == 9) ? 4'($urandom_range(0, 7)) : kinds[$urandom_range(0, 7)];
      run(mk_op(k, 3'($urandom)), 16'($urandom) & 16'h7fff, "random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule